// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block adds two 64-bit words as vectors of independent integer lanes, all lanes in the same cycle. A two-bit lane-size select splits the word into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. The carry chain is cut at every lane boundary of the selected size, so no lane ever sees a carry from its lower neighbour.

A mode bit picks the overflow behaviour. In wrap mode each lane drops its carry out and keeps the sum modulo its width. In saturating mode a lane whose unsigned sum overflows is forced to all ones, its largest value. Alongside the packed sum the block gives one flag per byte, set on every byte of a clamped lane. Result and flags are registered and appear one cycle after the input strobe, marked by an output strobe.

Top module: `psat_adder`

## Requirements
- R1: `out_valid_o` is high exactly one clock after a cycle in which `in_valid_i` was high, and low otherwise. A reset forces it low.
- R2: The lane size is encoded on `lane_sel_i` as 2'b00 for 8-bit, 2'b01 for 16-bit, 2'b10 for 32-bit and 2'b11 for 64-bit lanes. With `sat_mode_i` = 0 each lane of `sum_o` is (a + b) mod 2^width. For example, 200 + 120 in an 8-bit lane gives 64.
- R3: No carry crosses a lane boundary of the selected size. The carry out of the top bit of a lane affects only that lane.
- R4: With `sat_mode_i` = 1, a lane whose unsigned sum exceeds 2^width − 1 gives all ones. For example, 200 + 120 in an 8-bit lane gives 255.
- R5: With `sat_mode_i` = 1, a lane that does not overflow gives its exact sum.
- R6: `sat_flag_o[k]` refers to byte k (bits 8k+7..8k). It is 1 when, and only when, the lane containing byte k was clamped. Every byte of a clamped lane is flagged.
- R7: With `sat_mode_i` = 0 all bits of `sat_flag_o` are 0.
- R8: In a cycle with `in_valid_i` low, `sum_o` and `sat_flag_o` keep their previous values, whatever the operands, lane select and mode inputs are.
- R9: Lane i of `sum_o` uses the same bit positions as lane i of each operand, with lane 0 in the least significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid_i | input | 1 | Operands valid this cycle |
| opa_i | input | 64 | First packed operand |
| opb_i | input | 64 | Second packed operand |
| lane_sel_i | input | 2 | Lane size: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| sat_mode_i | input | 1 | 1 = unsigned saturating add, 0 = wrap-around add |
| out_valid_o | output | 1 | Result valid |
| sum_o | output | 64 | Packed lane sums |
| sat_flag_o | output | 8 | Per-byte clamp flags |

## Verification
The 8-bit lane configuration is swept nearly exhaustively. Every first operand value is paired with a stepped second operand, and a different offset is used in each byte, so every byte position sees both overflowing and non-overflowing sums in both modes. This separates a correct clamp from a wrap, and a cut carry chain from one that leaks. Directed vectors for the wider lane sizes place all-ones runs against a carry of one, so that a missing or misplaced boundary changes the sum. Pseudo-random vectors in both modes then compare against a per-lane arithmetic model for lane-position and flag-spreading errors. Idle cycles with changed operands confirm that the registered result holds.

// File: rtl/psat_pkg.sv
package psat_pkg;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam int unsigned NBYTES_DEF = 8;
  localparam int unsigned SEL_W      = 2;

  typedef enum logic [SEL_W-1:0] {
    LANE_B8  = 2'b00,
    LANE_B16 = 2'b01,
    LANE_B32 = 2'b10,
    LANE_B64 = 2'b11
  } lane_sel_e;
endpackage

// File: rtl/psat_lane_map.sv
// Turns the lane-size select into per-byte carry links and the index of the
// top byte of the lane that owns each byte.
module psat_lane_map #(
  parameter int unsigned NBYTES = psat_pkg::NBYTES_DEF,
  localparam int unsigned IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic [psat_pkg::SEL_W-1:0] lane_sel_i,
  output logic [NBYTES-1:0]          link_o,
  output logic [IDX_W-1:0]           end_idx_o [NBYTES]
);
  logic [IDX_W-1:0] span_m1;

  // Lane length in bytes minus one. It is truncated to IDX_W, which caps
  // the lane at the whole word.
  always_comb begin
    span_m1 = IDX_W'((32'd1 << lane_sel_i) - 32'd1);
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    localparam logic [IDX_W-1:0] POS = IDX_W'(g);
    if (g == 0) begin : g_first
      assign link_o[g] = 1'b0;
    end else begin : g_rest
      // A carry passes into byte g only if g is not the first byte of a lane.
      assign link_o[g] = |(POS & span_m1);
    end
    assign end_idx_o[g] = POS | span_m1;
  end
endmodule

// File: rtl/psat_byte_chain.sv
// Ripple of byte adders whose inter-byte carries pass only where link_i allows.
module psat_byte_chain #(
  parameter int unsigned BYTE_W = psat_pkg::BYTE_W_DEF,
  parameter int unsigned NBYTES = psat_pkg::NBYTES_DEF,
  localparam int unsigned DATA_W = BYTE_W * NBYTES
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [NBYTES-1:0] link_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [NBYTES-1:0] cout_o
);
  always_comb begin : p_chain
    logic            carry;
    logic [BYTE_W:0] part;
    carry = 1'b0;
    part  = '0;
    for (int g = 0; g < NBYTES; g++) begin
      part = {1'b0, a_i[g*BYTE_W +: BYTE_W]}
           + {1'b0, b_i[g*BYTE_W +: BYTE_W]}
           + {{BYTE_W{1'b0}}, carry & link_i[g]};
      sum_o[g*BYTE_W +: BYTE_W] = part[BYTE_W-1:0];
      cout_o[g]                 = part[BYTE_W];
      carry                     = part[BYTE_W];
    end
  end
endmodule

// File: rtl/psat_clamp.sv
// Clamps overflowing lanes to all ones in saturating mode and spreads the
// lane overflow to a flag on every byte of that lane.
module psat_clamp #(
  parameter int unsigned BYTE_W = psat_pkg::BYTE_W_DEF,
  parameter int unsigned NBYTES = psat_pkg::NBYTES_DEF,
  localparam int unsigned DATA_W = BYTE_W * NBYTES,
  localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic [NBYTES-1:0] cout_i,
  input  logic [IDX_W-1:0]  end_idx_i [NBYTES],
  input  logic              sat_mode_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NBYTES-1:0] flag_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign flag_o[g] = sat_mode_i & cout_i[end_idx_i[g]];
    assign res_o[g*BYTE_W +: BYTE_W] =
      flag_o[g] ? {BYTE_W{1'b1}} : raw_i[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/psat_adder.sv
module psat_adder #(
  parameter int unsigned BYTE_W = psat_pkg::BYTE_W_DEF,
  parameter int unsigned NBYTES = psat_pkg::NBYTES_DEF,
  localparam int unsigned DATA_W = BYTE_W * NBYTES,
  localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid_i,
  input  logic [DATA_W-1:0]           opa_i,
  input  logic [DATA_W-1:0]           opb_i,
  input  logic [psat_pkg::SEL_W-1:0]  lane_sel_i,
  input  logic                        sat_mode_i,
  output logic                        out_valid_o,
  output logic [DATA_W-1:0]           sum_o,
  output logic [NBYTES-1:0]           sat_flag_o
);
  // Reset: asynchronous assertion, synchronous release.
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // Datapath.
  logic [NBYTES-1:0] link;
  logic [IDX_W-1:0]  end_idx [NBYTES];
  logic [DATA_W-1:0] raw_sum;
  logic [NBYTES-1:0] carry_out;
  logic [DATA_W-1:0] res_d;
  logic [NBYTES-1:0] flag_d;

  psat_lane_map #(.NBYTES(NBYTES)) lane_map_i (
    .lane_sel_i (lane_sel_i),
    .link_o     (link),
    .end_idx_o  (end_idx)
  );

  psat_byte_chain #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) chain_i (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .link_i (link),
    .sum_o  (raw_sum),
    .cout_o (carry_out)
  );

  psat_clamp #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) clamp_i (
    .raw_i      (raw_sum),
    .cout_i     (carry_out),
    .end_idx_i  (end_idx),
    .sat_mode_i (sat_mode_i),
    .res_o      (res_d),
    .flag_o     (flag_d)
  );

  // Next state.
  logic              vld_d;
  logic              ld_en;
  logic              vld_q;
  logic [DATA_W-1:0] res_q;
  logic [NBYTES-1:0] flag_q;

  always_comb begin
    vld_d = in_valid_i;
    ld_en = in_valid_i;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      res_q  <= res_d;
      flag_q <= flag_d;
    end
  end

  assign out_valid_o = vld_q;
  assign sum_o       = res_q;
  assign sat_flag_o  = flag_q;
endmodule

// File: rtl/psat_adder_chk.sv
module psat_adder_chk #(
  parameter int unsigned BYTE_W = psat_pkg::BYTE_W_DEF,
  parameter int unsigned NBYTES = psat_pkg::NBYTES_DEF,
  localparam int unsigned DATA_W = BYTE_W * NBYTES
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic [psat_pkg::SEL_W-1:0] lane_sel,
  input logic                       sat_mode,
  input logic                       out_valid,
  input logic [DATA_W-1:0]          sum,
  input logic [NBYTES-1:0]          flags
);
  logic              past_ok;
  logic [DATA_W-1:0] flag_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb begin
    for (int g = 0; g < NBYTES; g++)
      flag_bits[g*BYTE_W +: BYTE_W] = {BYTE_W{flags[g]}};
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_valid == $past(in_valid)));

  // R7
  wrap_flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid && !sat_mode)) |-> (flags == '0));

  // R4
  clamp_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((sum & flag_bits) == flag_bits));

  // R6
  whole_word_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid && sat_mode && lane_sel == 2'b11))
      |-> (flags == '0 || flags == '1));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!in_valid)) |-> ($stable(sum) && $stable(flags)));
endmodule

bind psat_adder psat_adder_chk #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid_i),
  .lane_sel  (lane_sel_i),
  .sat_mode  (sat_mode_i),
  .out_valid (out_valid_o),
  .sum       (sum_o),
  .flags     (sat_flag_o)
);

// File: tb/psat_adder_tb.sv
`timescale 1ns/1ps
module psat_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic [1:0]  lane_sel = 2'b00;
  logic        sat_mode = 1'b0;
  logic        out_valid;
  logic [63:0] sum;
  logic [7:0]  flags;

  int n_vec  = 0;
  int n_fail = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;  // 125 MHz

  psat_adder dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid),
    .opa_i       (opa),
    .opb_i       (opb),
    .lane_sel_i  (lane_sel),
    .sat_mode_i  (sat_mode),
    .out_valid_o (out_valid),
    .sum_o       (sum),
    .sat_flag_o  (flags)
  );

  // Per-lane arithmetic model.
  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [1:0] sel, input logic sm,
                                output logic [63:0] r, output logic [7:0] f);
    int lb = 1 << sel;
    int w  = 8 * lb;
    logic [64:0] m;
    m = ({64'd0, 1'b1} << w) - 65'd1;
    r = '0;
    f = '0;
    for (int l = 0; l < 8 / lb; l++) begin
      logic [64:0] av, bv, s;
      av = ({1'b0, a} >> (l * w)) & m;
      bv = ({1'b0, b} >> (l * w)) & m;
      s  = av + bv;
      if (sm && (s > m)) begin
        r = r | (m[63:0] << (l * w));
        f = f | (8'((1 << lb) - 1) << (l * lb));
      end else begin
        r = r | ((s[63:0] & m[63:0]) << (l * w));
      end
    end
  endfunction

  function automatic logic [63:0] next_rng(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] sel, input logic sm);
    logic [63:0] er;
    logic [7:0]  ef;
    model(a, b, sel, sm, er, ef);
    @(negedge clk);
    in_valid = 1'b1; opa = a; opb = b; lane_sel = sel; sat_mode = sm;
    @(negedge clk);
    check64("R1 out_valid", {63'd0, out_valid}, 64'd1);
    if (sm) check64("R4 R5 R3 R9 sum", sum, er);
    else    check64("R2 R3 R9 sum", sum, er);
    if (sm) check64("R6 flags", {56'd0, flags}, {56'd0, ef});
    else    check64("R7 flags", {56'd0, flags}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check64("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check64("R1 idle out_valid", {63'd0, out_valid}, 64'd0);

    // R2 R4: 200 + 120 in 8-bit lanes
    apply({8{8'd200}}, {8{8'd120}}, 2'b00, 1'b0);
    check64("R2 200+120 wrap", sum, {8{8'd64}});
    apply({8{8'd200}}, {8{8'd120}}, 2'b00, 1'b1);
    check64("R4 200+120 sat", sum, {8{8'd255}});

    // R3: all-ones plus one at each lane size, wrap mode
    apply({8{8'hFF}}, {8{8'h01}}, 2'b00, 1'b0);
    check64("R3 8-bit cut", sum, 64'd0);
    apply({4{16'h00FF}}, {4{16'h0001}}, 2'b01, 1'b0);
    check64("R3 16-bit inner carry", sum, {4{16'h0100}});
    apply({4{16'hFFFF}}, {4{16'h0001}}, 2'b01, 1'b0);
    check64("R3 16-bit cut", sum, 64'd0);
    apply({2{32'hFFFF_FFFF}}, {2{32'h1}}, 2'b10, 1'b0);
    check64("R3 32-bit cut", sum, 64'd0);
    apply(64'h0000_0000_FFFF_FFFF, 64'h1, 2'b11, 1'b0);
    check64("R3 64-bit full carry", sum, 64'h1_0000_0000);
    apply('1, 64'h1, 2'b11, 1'b1);
    check64("R6 64-bit clamp flags", {56'd0, flags}, 64'hFF);

    // R9: one overflowing lane among quiet ones, 16-bit
    apply(64'h0001_FFFF_0002_0003, 64'h0001_0002_0003_0004, 2'b01, 1'b1);
    check64("R9 lane position", sum, 64'h0002_FFFF_0005_0007);
    check64("R6 lane flags", {56'd0, flags}, 64'h30);

    // R8: idle cycles with changed inputs keep the result
    begin
      logic [63:0] held_s;
      logic [7:0]  held_f;
      held_s = sum;
      held_f = flags;
      @(negedge clk);
      in_valid = 1'b0; opa = '1; opb = '1; lane_sel = 2'b00; sat_mode = 1'b0;
      repeat (2) @(negedge clk);
      check64("R8 hold sum", sum, held_s);
      check64("R8 hold flags", {56'd0, flags}, {56'd0, held_f});
      check64("R1 drop out_valid", {63'd0, out_valid}, 64'd0);
    end

    // Near-exhaustive 8-bit sweep, per-byte offsets
    for (int sm = 0; sm < 2; sm++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 5) begin
          logic [63:0] va, vb;
          for (int j = 0; j < 8; j++) begin
            va[j*8 +: 8] = 8'(a + j * 17);
            vb[j*8 +: 8] = 8'(b + j * 31);
          end
          apply(va, vb, 2'b00, sm[0]);
        end

    // Pseudo-random at wider lane sizes
    for (int sel = 1; sel < 4; sel++)
      for (int sm = 0; sm < 2; sm++)
        for (int k = 0; k < 800; k++) begin
          logic [63:0] va;
          rng = next_rng(rng); va = rng;
          rng = next_rng(rng);
          apply(va, rng, 2'(sel), sm[0]);
        end

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule